// File: doc/BRIEF.md
# Idle and power-down controller

This block sequences the low-power states of a small CPU core. An idle strobe stops the core clock and leaves the peripherals and the watchdog running. While the core is idle, the block watches the interrupt sources, the NMI pin and the watchdog, and decides what happens next. A qualified single-transfer service request is granted without waking the core, and the block goes back to idle once the transfer completes. A refused service request wakes the core. So does any normal interrupt that was enabled before idle was entered, at any priority. A falling NMI edge always wakes the core and raises a trap request. A watchdog overflow with no wake event raises an internal reset.

A power-down strobe stops all clocks and the watchdog. It can keep the real-time clock running, and it can switch off the main regulator. Power-down ends only through reset. The data-transfer engine, the interrupt vectoring logic, the clock generator and the regulator sit outside the block. They connect through the strobes and enables listed below.

Top module: `lpm_ctrl`

## Requirements
- R1: In idle, when the arbitration winner is a service request whose priority is strictly above `cpu_prio` and `glob_ien` is 1, the cycle after the request `xfer_grant` pulses with `xfer_src` = winner index and `mode` = 2 with no `wake`. The cycle after `xfer_done` is high, `mode` is back to 1.
- R2: In idle, a winning service request that is refused (priority not above `cpu_prio`, or `glob_ien` = 0) makes `wake` pulse and `mode` = 0 the next cycle, with no grant and no vector.
- R3: Requests are qualified by the enable bits captured from `req_en` in the cycle `idle_cmd` is accepted. A qualified normal request wakes the core whatever `cpu_prio` and `glob_ien` are. Changes to `req_en` during idle, and requests that are not qualified, leave `mode` at 1.
- R4: After a wake, `mode` stays 0 until a new `idle_cmd` or `pwrdn_cmd`.
- R5: A falling edge on `nmi_n` that has been low for three clock edges gives a one-cycle `nmi_trap`. From idle this also gives `wake` and `mode` = 0. In run mode it gives the trap alone.
- R6: `vec_take` pulses on a wake only when the winner is a normal request whose priority is above `cpu_prio` and `glob_ien` is 1. `vec_src` then gives the winner index. A priority-0 request never raises `vec_take`.
- R7: Source i's priority is `req_prio[i*PRIO_W +: PRIO_W]`, with 15 as the highest. The highest priority wins, and on a tie the lowest index wins.
- R8: A `wdt_ovf` in idle with no wake event in the same cycle makes `int_rst` pulse and `mode` = 0 the next cycle, with no `wake`. If a wake event arrives in the same cycle, it takes precedence and there is no reset.
- R9: In power-down (`mode` = 3), `cpu_clk_en`, `periph_clk_en` and `wdt_run` are 0, and `rtc_clk_en` holds the value `rtc_keep` had at entry. Requests, NMI edges and idle strobes leave it in power-down. One cycle after `rst` is asserted, the clocks and the regulator are enabled again.
- R10: On entry to power-down, `main_vreg_en` becomes the inverse of `vreg_off_arm` as sampled with `pwrdn_cmd`.
- R11: The mode code is 0 run, 1 idle, 2 transfer, 3 power-down. `cpu_clk_en` is 1 only in run. `periph_clk_en` and `wdt_run` are 1 in run, idle and transfer.
- R12: After reset, `mode` = 0, all clock enables, `wdt_run` and `main_vreg_en` are 1, and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_cmd | input | 1 | Idle instruction strobe |
| pwrdn_cmd | input | 1 | Power-down instruction strobe |
| req | input | N_SRC | Interrupt request per source |
| req_en | input | N_SRC | Individual enable per source |
| req_xfer | input | N_SRC | Source is set for single-transfer service |
| req_prio | input | N_SRC*PRIO_W | Packed priority levels |
| glob_ien | input | 1 | Global interrupt enable |
| cpu_prio | input | PRIO_W | Current CPU priority |
| nmi_n | input | 1 | Asynchronous NMI pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow |
| vreg_off_arm | input | 1 | Switch off the main regulator at power-down |
| rtc_keep | input | 1 | Keep the real-time clock running in power-down |
| xfer_done | input | 1 | Granted transfer has completed |
| mode | output | 2 | Current mode code |
| wake | output | 1 | Core woken (pulse) |
| nmi_trap | output | 1 | Enter NMI trap (pulse) |
| vec_take | output | 1 | Fetch vector for the winner (pulse) |
| vec_src | output | IDX_W | Source index for the vector |
| xfer_grant | output | 1 | Start a single transfer (pulse) |
| xfer_src | output | IDX_W | Source index for the transfer |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| rtc_clk_en | output | 1 | Real-time clock enable |
| wdt_run | output | 1 | Watchdog count enable |
| main_vreg_en | output | 1 | Main regulator enable |
| int_rst | output | 1 | Internal reset request (pulse) |

## Verification
The hardest case to reach is a cycle in idle where the winner's kind, priority, the CPU level, the global enable and the captured enable mask all line up to separate a granted transfer, a refused one, a vectored wake and a wake with no vector. Corrupted enables changed after entry have to be ignored in that same cycle. The stimulus gets there by entering idle with a random mask, scrambling `req_en` at once, and then presenting one cycle of random requests, service flags and packed priorities. A bench function picks the winner and the expected outcome for that cycle. Directed cases add the priority tie, a priority-0 wake, a watchdog overflow that collides with a request, and both regulator settings in power-down.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_XFER = 2'd2,
    MODE_DOWN = 2'd3
  } lpm_mode_e;
endpackage

// File: rtl/lpm_nmi_edge.sv
module lpm_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  output logic nmi_fall
);
  // stages [0..SYNC_STAGES-1] synchronize, the last one holds the previous value
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], nmi_n};
  end

  assign nmi_fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst) nmi_fall |=> !nmi_fall); // R5
endmodule

// File: rtl/lpm_arbiter.sv
module lpm_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]        valid,
  input  logic [N_SRC-1:0]        xfer,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  output logic                    any,
  output logic [IDX_W-1:0]        idx,
  output logic [PRIO_W-1:0]       win_prio,
  output logic                    win_xfer
);
  logic [PRIO_W-1:0] prio_arr [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_slice
    assign prio_arr[g] = prio[g*PRIO_W +: PRIO_W];
  end

  // linear scan: strict compare keeps the lowest index on a tie
  always_comb begin
    any      = 1'b0;
    idx      = '0;
    win_prio = '0;
    win_xfer = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (valid[i] && (!any || (prio_arr[i] > win_prio))) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        win_prio = prio_arr[i];
        win_xfer = xfer[i];
      end
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm import lpm_pkg::*; #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_cmd,
  input  logic              pwrdn_cmd,
  input  logic [N_SRC-1:0]  req_en,
  input  logic              glob_ien,
  input  logic [PRIO_W-1:0] cpu_prio,
  input  logic              nmi_fall,
  input  logic              wdt_ovf,
  input  logic              vreg_off_arm,
  input  logic              rtc_keep,
  input  logic              xfer_done,
  input  logic              arb_any,
  input  logic [IDX_W-1:0]  arb_idx,
  input  logic [PRIO_W-1:0] arb_prio,
  input  logic              arb_xfer,
  output logic [N_SRC-1:0]  en_snap,
  output lpm_mode_e         mode,
  output logic              wake,
  output logic              nmi_trap,
  output logic              vec_take,
  output logic [IDX_W-1:0]  vec_src,
  output logic              xfer_grant,
  output logic [IDX_W-1:0]  xfer_src,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              rtc_clk_en,
  output logic              wdt_run,
  output logic              main_vreg_en,
  output logic              int_rst
);
  lpm_mode_e        state_q, state_d;
  logic [N_SRC-1:0] snap_q, snap_d;
  logic             pend_q, pend_d;
  logic             wake_d, trap_d, vec_d, grant_d, irst_d;
  logic [IDX_W-1:0] vsrc_q, vsrc_d, xsrc_q, xsrc_d;
  logic             evt_nmi, above, can_service, can_vector;

  assign evt_nmi     = nmi_fall | pend_q;
  assign above       = glob_ien && (arb_prio > cpu_prio);
  assign can_service = arb_xfer && above;
  assign can_vector  = !arb_xfer && above;

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    pend_d  = pend_q | nmi_fall;
    wake_d  = 1'b0;
    trap_d  = 1'b0;
    vec_d   = 1'b0;
    grant_d = 1'b0;
    irst_d  = 1'b0;
    vsrc_d  = vsrc_q;
    xsrc_d  = xsrc_q;
    unique case (state_q)
      MODE_RUN: begin
        if (evt_nmi) begin
          trap_d = 1'b1;
          pend_d = 1'b0;
        end
        if (wdt_ovf) begin
          irst_d = 1'b1;
          snap_d = '0;
        end else if (!evt_nmi && pwrdn_cmd) begin
          state_d = MODE_DOWN;
        end else if (!evt_nmi && idle_cmd) begin
          state_d = MODE_IDLE;
          snap_d  = req_en;
        end
      end
      MODE_IDLE: begin
        if (evt_nmi) begin
          state_d = MODE_RUN;
          wake_d  = 1'b1;
          trap_d  = 1'b1;
          pend_d  = 1'b0;
        end else if (arb_any) begin
          if (can_service) begin
            state_d = MODE_XFER;
            grant_d = 1'b1;
            xsrc_d  = arb_idx;
          end else begin
            state_d = MODE_RUN;
            wake_d  = 1'b1;
            vec_d   = can_vector;
            if (can_vector) vsrc_d = arb_idx;
          end
        end else if (wdt_ovf) begin
          state_d = MODE_RUN;
          irst_d  = 1'b1;
          snap_d  = '0;
        end
      end
      MODE_XFER: begin
        if (wdt_ovf) begin
          state_d = MODE_RUN;
          irst_d  = 1'b1;
          snap_d  = '0;
        end else if (xfer_done) begin
          if (evt_nmi) begin
            state_d = MODE_RUN;
            wake_d  = 1'b1;
            trap_d  = 1'b1;
            pend_d  = 1'b0;
          end else begin
            state_d = MODE_IDLE;
          end
        end
      end
      MODE_DOWN: begin
        pend_d = 1'b0;
      end
      default: state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= MODE_RUN;
      snap_q     <= '0;
      pend_q     <= 1'b0;
      wake       <= 1'b0;
      nmi_trap   <= 1'b0;
      vec_take   <= 1'b0;
      xfer_grant <= 1'b0;
      int_rst    <= 1'b0;
      vsrc_q     <= '0;
      xsrc_q     <= '0;
    end else begin
      state_q    <= state_d;
      snap_q     <= snap_d;
      pend_q     <= pend_d;
      wake       <= wake_d;
      nmi_trap   <= trap_d;
      vec_take   <= vec_d;
      xfer_grant <= grant_d;
      int_rst    <= irst_d;
      vsrc_q     <= vsrc_d;
      xsrc_q     <= xsrc_d;
    end
  end

  // enables decoded from the next state and registered alongside it
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= 1'b1;
      wdt_run       <= 1'b1;
      main_vreg_en  <= 1'b1;
      rtc_clk_en    <= 1'b1;
    end else begin
      cpu_clk_en    <= (state_d == MODE_RUN);
      periph_clk_en <= (state_d != MODE_DOWN);
      wdt_run       <= (state_d != MODE_DOWN);
      if (state_d == MODE_DOWN && state_q != MODE_DOWN) begin
        main_vreg_en <= !vreg_off_arm;
        rtc_clk_en   <= rtc_keep;
      end else if (state_d != MODE_DOWN) begin
        main_vreg_en <= 1'b1;
        rtc_clk_en   <= 1'b1;
      end
    end
  end

  assign mode     = state_q;
  assign en_snap  = snap_q;
  assign vec_src  = vsrc_q;
  assign xfer_src = xsrc_q;

  AST_GRANT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) xfer_grant |-> (state_q == MODE_XFER) && ($past(state_q) == MODE_IDLE)); // R1
  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (rst) wake |-> (state_q == MODE_RUN) && ($past(state_q) != MODE_RUN)); // R2
  AST_NO_REIDLE: assert property (@(posedge clk) disable iff (rst) (state_q == MODE_RUN) && !idle_cmd && !pwrdn_cmd |=> (state_q == MODE_RUN)); // R4
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (rst) nmi_trap |=> !nmi_trap); // R5
  AST_VEC_LEVEL: assert property (@(posedge clk) disable iff (rst) vec_take |-> ($past(arb_prio) != '0)); // R6
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst) int_rst |-> $past(wdt_ovf)); // R8
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (rst) (state_q == MODE_DOWN) |=> (state_q == MODE_DOWN)); // R9
  AST_VREG_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(state_q == MODE_DOWN) |-> (main_vreg_en == !$past(vreg_off_arm))); // R10
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int N_SRC       = 8,
  parameter int PRIO_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    idle_cmd,
  input  logic                    pwrdn_cmd,
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC-1:0]        req_en,
  input  logic [N_SRC-1:0]        req_xfer,
  input  logic [N_SRC*PRIO_W-1:0] req_prio,
  input  logic                    glob_ien,
  input  logic [PRIO_W-1:0]       cpu_prio,
  input  logic                    nmi_n,
  input  logic                    wdt_ovf,
  input  logic                    vreg_off_arm,
  input  logic                    rtc_keep,
  input  logic                    xfer_done,
  output logic [1:0]              mode,
  output logic                    wake,
  output logic                    nmi_trap,
  output logic                    vec_take,
  output logic [IDX_W-1:0]        vec_src,
  output logic                    xfer_grant,
  output logic [IDX_W-1:0]        xfer_src,
  output logic                    cpu_clk_en,
  output logic                    periph_clk_en,
  output logic                    rtc_clk_en,
  output logic                    wdt_run,
  output logic                    main_vreg_en,
  output logic                    int_rst
);
  logic               nmi_fall;
  logic [N_SRC-1:0]   en_snap, act_mask;
  logic               arb_any, arb_xfer;
  logic [IDX_W-1:0]   arb_idx;
  logic [PRIO_W-1:0]  arb_prio;
  lpm_pkg::lpm_mode_e mode_e;

  assign act_mask = req & en_snap;

  lpm_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .nmi_fall(nmi_fall)
  );

  lpm_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .valid(act_mask), .xfer(req_xfer), .prio(req_prio),
    .any(arb_any), .idx(arb_idx), .win_prio(arb_prio), .win_xfer(arb_xfer)
  );

  lpm_fsm #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_fsm (
    .clk(clk), .rst(rst), .idle_cmd(idle_cmd), .pwrdn_cmd(pwrdn_cmd),
    .req_en(req_en), .glob_ien(glob_ien), .cpu_prio(cpu_prio),
    .nmi_fall(nmi_fall), .wdt_ovf(wdt_ovf), .vreg_off_arm(vreg_off_arm),
    .rtc_keep(rtc_keep), .xfer_done(xfer_done),
    .arb_any(arb_any), .arb_idx(arb_idx), .arb_prio(arb_prio), .arb_xfer(arb_xfer),
    .en_snap(en_snap), .mode(mode_e), .wake(wake), .nmi_trap(nmi_trap),
    .vec_take(vec_take), .vec_src(vec_src), .xfer_grant(xfer_grant),
    .xfer_src(xfer_src), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .rtc_clk_en(rtc_clk_en), .wdt_run(wdt_run), .main_vreg_en(main_vreg_en),
    .int_rst(int_rst)
  );

  assign mode = mode_e;

  AST_ARB_PICK: assert property (@(posedge clk) disable iff (rst) arb_any |-> act_mask[arb_idx]); // R7
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst, idle_cmd, pwrdn_cmd, glob_ien, nmi_n, wdt_ovf, vreg_off_arm, rtc_keep, xfer_done;
  logic [N-1:0]    req, req_en, req_xfer;
  logic [N*PW-1:0] req_prio;
  logic [PW-1:0]   cpu_prio;
  logic [1:0]      mode;
  logic            wake, nmi_trap, vec_take, xfer_grant;
  logic [IW-1:0]   vec_src, xfer_src;
  logic            cpu_clk_en, periph_clk_en, rtc_clk_en, wdt_run, main_vreg_en, int_rst;

  lpm_ctrl #(.N_SRC(N), .PRIO_W(PW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .idle_cmd(idle_cmd), .pwrdn_cmd(pwrdn_cmd),
    .req(req), .req_en(req_en), .req_xfer(req_xfer), .req_prio(req_prio),
    .glob_ien(glob_ien), .cpu_prio(cpu_prio), .nmi_n(nmi_n), .wdt_ovf(wdt_ovf),
    .vreg_off_arm(vreg_off_arm), .rtc_keep(rtc_keep), .xfer_done(xfer_done),
    .mode(mode), .wake(wake), .nmi_trap(nmi_trap), .vec_take(vec_take),
    .vec_src(vec_src), .xfer_grant(xfer_grant), .xfer_src(xfer_src),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .rtc_clk_en(rtc_clk_en),
    .wdt_run(wdt_run), .main_vreg_en(main_vreg_en), .int_rst(int_rst)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int prio_of(input int i);
    return int'(req_prio[i*PW +: PW]);
  endfunction

  function automatic int pick(input logic [N-1:0] v);
    int best = -1;
    int bp   = 0;
    for (int i = 0; i < N; i++)
      if (v[i] && (best < 0 || prio_of(i) > bp)) begin
        best = i;
        bp   = prio_of(i);
      end
    return best;
  endfunction

  task automatic set_prio(input int i, input int p);
    req_prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic enter_idle(input logic [N-1:0] en);
    req_en   = en;
    idle_cmd = 1'b1;
    tick();
    idle_cmd = 1'b0;
    chk("R11 mode idle", int'(mode), 1);
    chk("R11 cpu clk off in idle", int'(cpu_clk_en), 0);
    chk("R11 periph on in idle", int'(periph_clk_en & wdt_run), 1);
  endtask

  task automatic nmi_event(input int exp_wake);
    nmi_n = 1'b0;
    tick();
    tick();
    tick();
    chk("R5 nmi trap", int'(nmi_trap), 1);
    chk("R5 nmi wake", int'(wake), exp_wake);
    chk("R5 mode after nmi", int'(mode), 0);
    nmi_n = 1'b1;
    tick();
    chk("R5 trap single", int'(nmi_trap), 0);
    tick();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7741);
    rst = 1'b1; idle_cmd = 0; pwrdn_cmd = 0; glob_ien = 0; nmi_n = 1;
    wdt_ovf = 0; vreg_off_arm = 0; rtc_keep = 0; xfer_done = 0;
    req = '0; req_en = '0; req_xfer = '0; req_prio = '0; cpu_prio = '0;
    @(negedge clk);
    do_reset();

    // R12 reset state
    chk("R12 mode", int'(mode), 0);
    chk("R12 enables", int'({cpu_clk_en, periph_clk_en, rtc_clk_en, wdt_run, main_vreg_en}), 31);
    chk("R12 strobes", int'({wake, nmi_trap, vec_take, xfer_grant, int_rst}), 0);

    // R5 NMI in run mode: trap only
    nmi_event(0);

    // R5 NMI in idle
    enter_idle(8'h00);
    nmi_event(1);

    // R3 snapshot: later enable changes ignored, unqualified request ignored
    enter_idle(8'h01);
    req_en = 8'hFF;
    req = 8'h02; set_prio(1, 12); glob_ien = 1; cpu_prio = 0;
    tick();
    chk("R3 unqualified ignored", int'(mode), 1);
    chk("R3 no wake", int'(wake), 0);
    req = 8'h01; req_xfer = 8'h00; set_prio(0, 3); glob_ien = 0; cpu_prio = 15;
    tick();
    req = 8'h00;
    chk("R3 wake despite ien=0", int'(wake), 1);
    chk("R3 mode run", int'(mode), 0);
    chk("R6 no vector when ien=0", int'(vec_take), 0);
    tick();
    chk("R4 stays run", int'(mode), 0);

    // R6 priority-0 wake without vector
    enter_idle(8'h01);
    req = 8'h01; set_prio(0, 0); glob_ien = 1; cpu_prio = 0;
    tick();
    req = 8'h00;
    chk("R6 prio0 wake", int'(wake), 1);
    chk("R6 prio0 no vector", int'(vec_take), 0);

    // R7 tie: lower index wins
    enter_idle(8'h0C);
    req = 8'h0C; set_prio(2, 7); set_prio(3, 7); glob_ien = 1; cpu_prio = 1;
    tick();
    req = 8'h00;
    chk("R7 tie vector", int'(vec_take), 1);
    chk("R7 tie lowest index", int'(vec_src), 2);

    // R1 granted transfer then back to idle
    enter_idle(8'h20);
    req = 8'h20; req_xfer = 8'h20; set_prio(5, 9); glob_ien = 1; cpu_prio = 4;
    tick();
    req = 8'h00;
    chk("R1 grant", int'(xfer_grant), 1);
    chk("R1 grant src", int'(xfer_src), 5);
    chk("R1 mode xfer", int'(mode), 2);
    chk("R1 no wake", int'(wake), 0);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R1 back to idle", int'(mode), 1);

    // R2 refused transfer (ien=0) wakes
    req = 8'h20; glob_ien = 0;
    tick();
    req = 8'h00; req_xfer = 8'h00;
    chk("R2 refused wake", int'(wake), 1);
    chk("R2 no grant", int'(xfer_grant), 0);
    chk("R2 mode run", int'(mode), 0);

    // R8 watchdog in idle
    enter_idle(8'h00);
    wdt_ovf = 1'b1;
    tick();
    wdt_ovf = 1'b0;
    chk("R8 int reset", int'(int_rst), 1);
    chk("R8 no wake", int'(wake), 0);
    chk("R8 mode run", int'(mode), 0);
    tick();
    chk("R8 reset pulse ends", int'(int_rst), 0);

    // R8 request beats watchdog
    enter_idle(8'h01);
    req = 8'h01; set_prio(0, 5); glob_ien = 1; cpu_prio = 0; wdt_ovf = 1'b1;
    tick();
    req = 8'h00; wdt_ovf = 1'b0;
    chk("R8 wake wins", int'(wake), 1);
    chk("R8 no reset on wake", int'(int_rst), 0);

    // R9/R10 power-down with regulator off and RTC kept
    vreg_off_arm = 1; rtc_keep = 1; pwrdn_cmd = 1;
    tick();
    pwrdn_cmd = 0; vreg_off_arm = 0; rtc_keep = 0;
    chk("R11 mode down", int'(mode), 3);
    chk("R9 clocks off", int'({cpu_clk_en, periph_clk_en, wdt_run}), 0);
    chk("R9 rtc kept", int'(rtc_clk_en), 1);
    chk("R10 regulator off", int'(main_vreg_en), 0);
    req_en = 8'hFF; req = 8'hFF; nmi_n = 0; idle_cmd = 1;
    repeat (4) tick();
    req = 8'h00; nmi_n = 1; idle_cmd = 0;
    chk("R9 stays down", int'(mode), 3);
    chk("R9 no wake in down", int'(wake | nmi_trap), 0);
    repeat (3) tick();
    rst = 1'b1;
    tick();
    chk("R9 clocks back after reset", int'({cpu_clk_en, periph_clk_en, wdt_run}), 7);
    chk("R9 regulator back", int'(main_vreg_en), 1);
    rst = 1'b0;
    tick();

    // R10 power-down with regulator kept
    vreg_off_arm = 0; rtc_keep = 0; pwrdn_cmd = 1;
    tick();
    pwrdn_cmd = 0;
    chk("R10 regulator kept", int'(main_vreg_en), 1);
    chk("R9 rtc stopped", int'(rtc_clk_en), 0);
    do_reset();

    // random idle-cycle outcomes
    for (int it = 0; it < 150; it++) begin
      logic [N-1:0] snap;
      int w;
      bit acc, vec;
      snap     = N'($urandom);
      cpu_prio = PW'($urandom);
      glob_ien = 1'($urandom);
      enter_idle(snap);
      req_en   = N'($urandom);
      req_xfer = N'($urandom);
      req_prio = $urandom;
      req      = N'($urandom & $urandom);
      w   = pick(req & snap);
      acc = (w >= 0) && req_xfer[w] && glob_ien && (prio_of(w) > int'(cpu_prio));
      vec = (w >= 0) && !req_xfer[w] && glob_ien && (prio_of(w) > int'(cpu_prio));
      tick();
      req = '0;
      if (w < 0) begin
        chk("R3 no qualified request", int'(mode), 1);
        chk("R3 no wake", int'(wake), 0);
        nmi_event(1);
      end else if (acc) begin
        chk("R1 rand grant", int'(xfer_grant), 1);
        chk("R7 rand grant src", int'(xfer_src), w);
        chk("R1 rand mode", int'(mode), 2);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R1 rand return", int'(mode), 1);
        nmi_event(1);
      end else begin
        chk("R2 rand wake", int'(wake), 1);
        chk("R2 rand no grant", int'(xfer_grant), 0);
        chk("R6 rand vector", int'(vec_take), int'(vec));
        if (vec) chk("R7 rand vec src", int'(vec_src), w);
        tick();
        chk("R4 rand stays run", int'(mode), 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule